// File: doc/BRIEF.md
# Prefetcher Training Event Qualifier

This block sits between a cache and a hardware prefetch engine. For every cache access the cache presents, it decides whether that access should become a training event for the prefetcher. The access comes with its attributes: hit or miss, instruction fetch, write, invalidate, uncacheable, software prefetch, cache maintenance, clean-evict, secure, whether the target line was brought in by a prefetch, and a physical and a virtual address.

A set of static configuration inputs selects the filtering policy. These inputs are assumed stable while accesses are flowing. The decision is made combinationally as a single priority chain. The result is registered into a one-cycle training pulse. The pulse carries the chosen address, its block-aligned form, its page offset, and the secure, write and miss flags.

Alongside the filter, two saturating counters measure prefetch usefulness. The first counts accesses that land on prefetched lines. The second counts the subset of those that missed, meaning the line was present but not in a usable coherence state.

The filter is organised as a decision chain over an enumerated reason code. The reason codes, in priority order, are:

- CMD: a software prefetch or maintenance operation.
- COALESCE: a write to a coalescing cache.
- PFHIT_YES / PFHIT_NO: a hit, judged by the prefetched-line rule.
- HIT_OFF: a hit while hit training is disabled.
- UNCACHE: an uncacheable access.
- INST_OFF: a fetch while fetch training is disabled.
- DATA_OFF: a data access while data training is disabled.
- READ_OFF: a read while read training is disabled.
- WRITE_OFF: a write while write training is disabled.
- INV_WRITE: a write that carries an invalidate.
- EVICT: a clean-evict command.
- MISS_YES / MISS_NO: the outcome under miss-only mode.
- PASS: no rule rejected the access.
- NO_VA: applied last, and only to an accepted access in virtual-address mode whose virtual address is not valid.

Only PASS, PFHIT_YES and MISS_YES forward an event.

Top module: `pfq_train_qualifier`

## Requirements
- R1: An access flagged as software prefetch or cache maintenance is never forwarded and changes neither counter.
- R2: With `cfg_coalesce` set, a write access is dropped and changes neither counter; reads are unaffected.
- R3: Every access not excluded by R1/R2 whose `evt_line_pf` is 1 increments `useful_cnt` by one.
- R4: Such an access that is also a miss (`evt_miss`=1) additionally increments `unusable_cnt` by one.
- R5: On a hit with `cfg_on_pfhit`=1, the event is forwarded exactly when `evt_line_pf`=1, regardless of uncacheable, type-enable, invalidate, clean-evict and miss-only rules.
- R6: On a hit with `cfg_on_pfhit`=0 and `cfg_on_access`=0, the event is rejected.
- R7: Uncacheable accesses are rejected. Instruction fetches are rejected unless `cfg_en_inst`=1.
- R8: For non-fetch accesses, the following are rejected: all of them when `cfg_en_data`=0; reads (`evt_write`=0) when `cfg_en_read`=0; writes when `cfg_en_write`=0; and writes with `evt_inval`=1.
- R9: Clean-evict accesses are rejected. With `cfg_miss_only`=1, a surviving access is forwarded exactly when it is a miss; otherwise it is forwarded.
- R10: With `cfg_use_va`=1, the forwarded address is `evt_va`, and an otherwise accepted access with `evt_va_ok`=0 is dropped. With `cfg_use_va`=0, the forwarded address is `evt_pa`.
- R11: `train_blk_addr` is the forwarded address with its low log2(BLK_BYTES) bits cleared. `train_page_off` is the forwarded address ANDed with PAGE_BYTES-1.
- R12: `train_valid` pulses for exactly the one cycle after the clock edge that samples an accepted access. It comes with `train_secure`, `train_write` and `train_miss` copied from that access, and it is 0 after reset.
- R13: Both counters are CNT_W bits wide, hold at all ones once reached, and are cleared to zero by the synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_inst | input | 1 | Train on instruction fetches |
| cfg_en_data | input | 1 | Train on data accesses |
| cfg_en_read | input | 1 | Train on data reads |
| cfg_en_write | input | 1 | Train on data writes |
| cfg_miss_only | input | 1 | Forward only misses |
| cfg_on_access | input | 1 | Consider hits as well as misses |
| cfg_on_pfhit | input | 1 | On hits, forward exactly the prefetched-line hits |
| cfg_use_va | input | 1 | Forward virtual instead of physical address |
| cfg_coalesce | input | 1 | Cache is coalescing writes |
| evt_valid | input | 1 | Access strobe |
| evt_miss | input | 1 | Access missed |
| evt_fetch | input | 1 | Instruction fetch |
| evt_write | input | 1 | Write access (0 = read) |
| evt_inval | input | 1 | Access carries an invalidate |
| evt_uncache | input | 1 | Uncacheable access |
| evt_swpf | input | 1 | Software prefetch command |
| evt_cmo | input | 1 | Cache maintenance operation |
| evt_evict | input | 1 | Clean-evict command |
| evt_secure | input | 1 | Secure access |
| evt_line_pf | input | 1 | Target line was prefetched |
| evt_pa | input | ADDR_W | Physical address |
| evt_va | input | ADDR_W | Virtual address |
| evt_va_ok | input | 1 | Virtual address valid |
| train_valid | output | 1 | Training event pulse |
| train_addr | output | ADDR_W | Forwarded address |
| train_blk_addr | output | ADDR_W | Block-aligned forwarded address |
| train_page_off | output | PG_W | Page offset of forwarded address |
| train_secure | output | 1 | Secure flag of the event |
| train_write | output | 1 | Write flag of the event |
| train_miss | output | 1 | Miss flag of the event |
| useful_cnt | output | CNT_W | Accesses to prefetched lines |
| unusable_cnt | output | CNT_W | Misses on prefetched lines |

## Verification
Directed cases walk the priority chain one link at a time. Each case is a pair of accesses that differ only in the attribute a rule tests. This shows that each rejection fires on its own condition and not on a neighbour's. The pairs include a prefetched-line hit that is also uncacheable, to show that the hit rule overrides the later rules. They also include an invalid virtual address with virtual mode on and off. Random accesses under many random configurations then mix all attributes. They are compared against a bench model for the forward decision, the address split and both counters. A long run of prefetched-line misses drives the counters into saturation and shows that they hold there.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef struct packed {
        logic en_inst;
        logic en_data;
        logic en_read;
        logic en_write;
        logic miss_only;
        logic on_access;
        logic on_pfhit;
        logic use_va;
        logic coalesce;
    } pfq_cfg_t;

    typedef struct packed {
        logic miss;
        logic fetch;
        logic write;
        logic inval;
        logic uncache;
        logic swpf;
        logic cmo;
        logic evict;
        logic line_pf;
        logic va_ok;
    } pfq_attr_t;

    typedef enum logic [3:0] {
        RSN_PASS,
        RSN_CMD,
        RSN_COALESCE,
        RSN_PFHIT_YES,
        RSN_PFHIT_NO,
        RSN_HIT_OFF,
        RSN_UNCACHE,
        RSN_INST_OFF,
        RSN_DATA_OFF,
        RSN_READ_OFF,
        RSN_WRITE_OFF,
        RSN_INV_WRITE,
        RSN_EVICT,
        RSN_MISS_YES,
        RSN_MISS_NO,
        RSN_NO_VA
    } pfq_reason_e;

endpackage

// File: rtl/pfq_rule_filter.sv
module pfq_rule_filter
    import pfq_pkg::*;
(
    input  pfq_cfg_t    cfg,
    input  pfq_attr_t   attr,
    output pfq_reason_e reason,
    output logic        take,
    output logic        count_ok
);

    pfq_reason_e base_rsn;
    logic        base_take;

    // Priority chain: the first matching rule names the outcome.
    always_comb begin
        base_rsn = RSN_PASS;
        if (attr.swpf || attr.cmo)
            base_rsn = RSN_CMD;
        else if (attr.write && cfg.coalesce)
            base_rsn = RSN_COALESCE;
        else if (!attr.miss && cfg.on_pfhit)
            base_rsn = attr.line_pf ? RSN_PFHIT_YES : RSN_PFHIT_NO;
        else if (!attr.miss && !cfg.on_access)
            base_rsn = RSN_HIT_OFF;
        else if (attr.uncache)
            base_rsn = RSN_UNCACHE;
        else if (attr.fetch && !cfg.en_inst)
            base_rsn = RSN_INST_OFF;
        else if (!attr.fetch && !cfg.en_data)
            base_rsn = RSN_DATA_OFF;
        else if (!attr.fetch && !attr.write && !cfg.en_read)
            base_rsn = RSN_READ_OFF;
        else if (!attr.fetch && attr.write && !cfg.en_write)
            base_rsn = RSN_WRITE_OFF;
        else if (!attr.fetch && attr.write && attr.inval)
            base_rsn = RSN_INV_WRITE;
        else if (attr.evict)
            base_rsn = RSN_EVICT;
        else if (cfg.miss_only)
            base_rsn = attr.miss ? RSN_MISS_YES : RSN_MISS_NO;
    end

    always_comb begin
        unique case (base_rsn)
            RSN_PASS, RSN_PFHIT_YES, RSN_MISS_YES: base_take = 1'b1;
            default:                               base_take = 1'b0;
        endcase
    end

    // Address availability is checked last, only on otherwise accepted accesses.
    always_comb begin
        reason = base_rsn;
        if (base_take && cfg.use_va && !attr.va_ok)
            reason = RSN_NO_VA;
    end

    always_comb begin
        unique case (reason)
            RSN_PASS, RSN_PFHIT_YES, RSN_MISS_YES: take = 1'b1;
            default:                               take = 1'b0;
        endcase
    end

    assign count_ok = !(attr.swpf || attr.cmo) && !(attr.write && cfg.coalesce);

    always_comb begin
        if (take) begin
            a_take_not_cmd_r1: assert (!attr.swpf && !attr.cmo);
        end
    end

endmodule

// File: rtl/pfq_sat_counter.sv
module pfq_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));
    p_saturate_r13: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt == CNT_MAX) |=> cnt == CNT_MAX);

endmodule

// File: rtl/pfq_addr_split.sv
module pfq_addr_split #(
    parameter int ADDR_W     = 48,
    parameter int BLK_BYTES  = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [ADDR_W-1:0]             blk_addr,
    output logic [$clog2(PAGE_BYTES)-1:0] page_off
);

    localparam int BLK_W = $clog2(BLK_BYTES);
    localparam int PG_W  = $clog2(PAGE_BYTES);

    assign blk_addr = {addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
    assign page_off = addr[PG_W-1:0];

endmodule

// File: rtl/pfq_train_qualifier.sv
module pfq_train_qualifier
    import pfq_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int BLK_BYTES  = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int CNT_W      = 32,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en_inst,
    input  logic              cfg_en_data,
    input  logic              cfg_en_read,
    input  logic              cfg_en_write,
    input  logic              cfg_miss_only,
    input  logic              cfg_on_access,
    input  logic              cfg_on_pfhit,
    input  logic              cfg_use_va,
    input  logic              cfg_coalesce,
    input  logic              evt_valid,
    input  logic              evt_miss,
    input  logic              evt_fetch,
    input  logic              evt_write,
    input  logic              evt_inval,
    input  logic              evt_uncache,
    input  logic              evt_swpf,
    input  logic              evt_cmo,
    input  logic              evt_evict,
    input  logic              evt_secure,
    input  logic              evt_line_pf,
    input  logic [ADDR_W-1:0] evt_pa,
    input  logic [ADDR_W-1:0] evt_va,
    input  logic              evt_va_ok,
    output logic              train_valid,
    output logic [ADDR_W-1:0] train_addr,
    output logic [ADDR_W-1:0] train_blk_addr,
    output logic [PG_W-1:0]   train_page_off,
    output logic              train_secure,
    output logic              train_write,
    output logic              train_miss,
    output logic [CNT_W-1:0]  useful_cnt,
    output logic [CNT_W-1:0]  unusable_cnt
);

    localparam int N_CNT = 2;

    pfq_cfg_t    cfg;
    pfq_attr_t   attr;
    pfq_reason_e reason;
    logic        take;
    logic        count_ok;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] sel_blk;
    logic [PG_W-1:0]   sel_off;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    assign cfg = '{en_inst:   cfg_en_inst,
                   en_data:   cfg_en_data,
                   en_read:   cfg_en_read,
                   en_write:  cfg_en_write,
                   miss_only: cfg_miss_only,
                   on_access: cfg_on_access,
                   on_pfhit:  cfg_on_pfhit,
                   use_va:    cfg_use_va,
                   coalesce:  cfg_coalesce};

    assign attr = '{miss:    evt_miss,
                    fetch:   evt_fetch,
                    write:   evt_write,
                    inval:   evt_inval,
                    uncache: evt_uncache,
                    swpf:    evt_swpf,
                    cmo:     evt_cmo,
                    evict:   evt_evict,
                    line_pf: evt_line_pf,
                    va_ok:   evt_va_ok};

    pfq_rule_filter u_filter (
        .cfg      (cfg),
        .attr     (attr),
        .reason   (reason),
        .take     (take),
        .count_ok (count_ok)
    );

    assign sel_addr = cfg_use_va ? evt_va : evt_pa;

    pfq_addr_split #(
        .ADDR_W     (ADDR_W),
        .BLK_BYTES  (BLK_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_split (
        .addr     (sel_addr),
        .blk_addr (sel_blk),
        .page_off (sel_off)
    );

    assign cnt_inc[0] = evt_valid && count_ok && evt_line_pf;
    assign cnt_inc[1] = evt_valid && count_ok && evt_line_pf && evt_miss;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        pfq_sat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (cnt_inc[g]),
            .cnt (cnt_val[g])
        );
    end

    assign useful_cnt   = cnt_val[0];
    assign unusable_cnt = cnt_val[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            train_valid    <= 1'b0;
            train_addr     <= '0;
            train_blk_addr <= '0;
            train_page_off <= '0;
            train_secure   <= 1'b0;
            train_write    <= 1'b0;
            train_miss     <= 1'b0;
        end else begin
            train_valid <= evt_valid && take;
            if (evt_valid && take) begin
                train_addr     <= sel_addr;
                train_blk_addr <= sel_blk;
                train_page_off <= sel_off;
                train_secure   <= evt_secure;
                train_write    <= evt_write;
                train_miss     <= evt_miss;
            end
        end
    end

    p_pulse_from_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        train_valid |-> $past(evt_valid));
    p_cmd_dropped_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (evt_swpf || evt_cmo)) |=> !train_valid);
    p_no_va_dropped_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && cfg_use_va && !evt_va_ok) |=> !train_valid);
    p_uncache_miss_dropped_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_miss && evt_uncache) |=> !train_valid);
    p_unusable_with_useful_r4: assert property (@(posedge clk) disable iff (rst)
        (unusable_cnt != $past(unusable_cnt)) |->
        (useful_cnt != $past(useful_cnt) || useful_cnt == {CNT_W{1'b1}}));

endmodule

// File: tb/sim_pfq_train_qualifier.sv
`timescale 1ns/1ps
module sim_pfq_train_qualifier;

    localparam int ADDR_W = 48;
    localparam int BLKB   = 64;
    localparam int PAGEB  = 4096;
    localparam int CNT_W  = 8;
    localparam int PG_W   = $clog2(PAGEB);
    localparam logic [63:0] CMAX = (64'd1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_inst, c_data, c_read, c_write, c_monly, c_acc, c_pfh, c_va, c_coal;
    logic e_valid, e_miss, e_fetch, e_write, e_inval, e_unc, e_swpf, e_cmo, e_evict, e_sec, e_lpf, e_vaok;
    logic [ADDR_W-1:0] e_pa, e_va;
    logic t_valid, t_sec, t_write, t_miss;
    logic [ADDR_W-1:0] t_addr, t_blk;
    logic [PG_W-1:0] t_off;
    logic [CNT_W-1:0] u_cnt, x_cnt;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_useful = 0;
    logic [63:0] m_unusable = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pfq_train_qualifier #(.ADDR_W(ADDR_W), .BLK_BYTES(BLKB), .PAGE_BYTES(PAGEB), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst),
        .cfg_en_inst(c_inst), .cfg_en_data(c_data), .cfg_en_read(c_read), .cfg_en_write(c_write),
        .cfg_miss_only(c_monly), .cfg_on_access(c_acc), .cfg_on_pfhit(c_pfh), .cfg_use_va(c_va),
        .cfg_coalesce(c_coal),
        .evt_valid(e_valid), .evt_miss(e_miss), .evt_fetch(e_fetch), .evt_write(e_write),
        .evt_inval(e_inval), .evt_uncache(e_unc), .evt_swpf(e_swpf), .evt_cmo(e_cmo),
        .evt_evict(e_evict), .evt_secure(e_sec), .evt_line_pf(e_lpf),
        .evt_pa(e_pa), .evt_va(e_va), .evt_va_ok(e_vaok),
        .train_valid(t_valid), .train_addr(t_addr), .train_blk_addr(t_blk),
        .train_page_off(t_off), .train_secure(t_sec), .train_write(t_write),
        .train_miss(t_miss), .useful_cnt(u_cnt), .unusable_cnt(x_cnt)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Forward decision from the requirements (R1, R2, R5..R10).
    function automatic bit model_take();
        if (e_swpf || e_cmo) return 0;
        if (e_write && c_coal) return 0;
        if (!e_miss && c_pfh) return e_lpf && (!c_va || e_vaok);
        if (!e_miss && !c_acc) return 0;
        if (e_unc) return 0;
        if (e_fetch && !c_inst) return 0;
        if (!e_fetch && !c_data) return 0;
        if (!e_fetch && !e_write && !c_read) return 0;
        if (!e_fetch && e_write && !c_write) return 0;
        if (!e_fetch && e_write && e_inval) return 0;
        if (e_evict) return 0;
        if (c_monly && !e_miss) return 0;
        return !c_va || e_vaok;
    endfunction

    task automatic cfg_default();
        c_inst = 1; c_data = 1; c_read = 1; c_write = 1; c_monly = 0;
        c_acc = 1; c_pfh = 0; c_va = 0; c_coal = 0;
    endtask

    task automatic clr_evt();
        e_valid = 0; e_miss = 1; e_fetch = 0; e_write = 0; e_inval = 0; e_unc = 0;
        e_swpf = 0; e_cmo = 0; e_evict = 0; e_sec = 0; e_lpf = 0; e_vaok = 1;
        e_pa = 48'h1234_5678_9ABC; e_va = 48'h0FED_CBA9_8765;
    endtask

    // Called just after a falling edge with event inputs set; checks after the next rise.
    task automatic fire(input string tag, input bit use_want, input bit want);
        bit exp_t;
        bit cnt_ok;
        logic [63:0] a, eb, eo;
        bit s, w, m;
        e_valid = 1;
        exp_t = model_take();
        if (use_want) chk(exp_t == want, {tag, " bench-model"}, exp_t, want);
        cnt_ok = !(e_swpf || e_cmo) && !(e_write && c_coal);
        if (cnt_ok && e_lpf) begin
            if (m_useful != CMAX) m_useful++;
            if (e_miss && m_unusable != CMAX) m_unusable++;
        end
        a = c_va ? 64'(e_va) : 64'(e_pa);
        eb = a & ~64'(BLKB - 1);
        eo = a & 64'(PAGEB - 1);
        s = e_sec; w = e_write; m = e_miss;
        @(negedge clk);
        e_valid = 0;
        chk(t_valid == exp_t, {tag, " valid"}, t_valid, exp_t);
        if (exp_t && t_valid) begin
            chk(64'(t_addr) == a, "R10 addr", t_addr, a);
            chk(64'(t_blk) == eb, "R11 blk", t_blk, eb);
            chk(64'(t_off) == eo, "R11 off", t_off, eo);
            chk({t_sec, t_write, t_miss} == {s, w, m}, "R12 flags", {t_sec, t_write, t_miss}, {s, w, m});
        end
        chk(64'(u_cnt) == m_useful, "R3 useful", u_cnt, m_useful);
        chk(64'(x_cnt) == m_unusable, "R4 unusable", x_cnt, m_unusable);
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cfg_default();
        clr_evt();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(t_valid == 0, "R12 reset valid", t_valid, 0);
        chk(u_cnt == 0 && x_cnt == 0, "R13 reset cnt", {u_cnt, x_cnt}, 0);

        // R1
        clr_evt(); e_swpf = 1; e_lpf = 1; fire("R1 swpf", 1, 0);
        clr_evt(); e_cmo = 1; e_lpf = 1; fire("R1 cmo", 1, 0);
        // R2
        c_coal = 1;
        clr_evt(); e_write = 1; e_lpf = 1; fire("R2 coalesced write", 1, 0);
        clr_evt(); e_lpf = 1; fire("R2 read passes", 1, 1);
        c_coal = 0;
        // R3 / R4
        clr_evt(); e_miss = 0; e_lpf = 1; fire("R3 pf hit", 1, 1);
        clr_evt(); e_miss = 1; e_lpf = 1; fire("R4 pf miss", 1, 1);
        // R5
        c_pfh = 1;
        clr_evt(); e_miss = 0; e_lpf = 1; e_unc = 1; e_evict = 1; fire("R5 pf hit overrides", 1, 1);
        clr_evt(); e_miss = 0; e_lpf = 0; fire("R5 plain hit", 1, 0);
        c_pfh = 0;
        // R6
        c_acc = 0;
        clr_evt(); e_miss = 0; fire("R6 hit off", 1, 0);
        clr_evt(); e_miss = 1; fire("R6 miss still", 1, 1);
        c_acc = 1;
        // R7
        clr_evt(); e_unc = 1; fire("R7 uncache", 1, 0);
        c_inst = 0; clr_evt(); e_fetch = 1; fire("R7 fetch off", 1, 0);
        c_inst = 1; clr_evt(); e_fetch = 1; fire("R7 fetch on", 1, 1);
        // R8
        c_data = 0; clr_evt(); fire("R8 data off", 1, 0);
        clr_evt(); e_fetch = 1; fire("R8 fetch ignores data off", 1, 1);
        c_data = 1; c_read = 0; clr_evt(); fire("R8 read off", 1, 0);
        clr_evt(); e_write = 1; fire("R8 write under read off", 1, 1);
        c_read = 1; c_write = 0; clr_evt(); e_write = 1; fire("R8 write off", 1, 0);
        c_write = 1; clr_evt(); e_write = 1; e_inval = 1; fire("R8 inval write", 1, 0);
        clr_evt(); e_inval = 1; fire("R8 inval read", 1, 1);
        // R9
        clr_evt(); e_evict = 1; fire("R9 evict", 1, 0);
        c_monly = 1;
        clr_evt(); e_miss = 0; fire("R9 miss-only hit", 1, 0);
        clr_evt(); e_miss = 1; e_sec = 1; fire("R9 miss-only miss", 1, 1);
        c_monly = 0;
        // R10
        c_va = 1;
        clr_evt(); e_vaok = 0; fire("R10 no va", 1, 0);
        clr_evt(); e_va = 48'hABCD_EF01_2345; fire("R10 va sel", 1, 1);
        c_va = 0;
        clr_evt(); e_vaok = 0; fire("R10 pa ignores va_ok", 1, 1);
        // R12 pulse width
        @(negedge clk);
        chk(t_valid == 0, "R12 one cycle", t_valid, 0);

        // random phase
        for (int k = 0; k < 30; k++) begin
            {c_inst, c_data, c_read, c_write, c_monly, c_acc, c_pfh, c_va, c_coal} = 9'($urandom);
            @(negedge clk);
            for (int j = 0; j < 40; j++) begin
                clr_evt();
                e_miss = $urandom % 2; e_fetch = ($urandom % 4) == 0;
                e_write = !e_fetch && ($urandom % 2);
                e_inval = ($urandom % 4) == 0; e_unc = ($urandom % 6) == 0;
                e_swpf = ($urandom % 10) == 0; e_cmo = ($urandom % 10) == 0;
                e_evict = ($urandom % 8) == 0; e_sec = $urandom % 2;
                e_lpf = $urandom % 2; e_vaok = ($urandom % 5) != 0;
                e_pa = {16'($urandom), 32'($urandom)};
                e_va = {16'($urandom), 32'($urandom)};
                fire("R12 random", 0, 0);
                if ($urandom % 3 == 0) @(negedge clk);
            end
        end

        // R13 saturation
        cfg_default();
        for (int j = 0; j < 300; j++) begin
            clr_evt(); e_lpf = 1; e_miss = 1;
            fire("R13 saturate", 0, 0);
        end
        chk(64'(u_cnt) == CMAX, "R13 useful sat", u_cnt, CMAX);
        chk(64'(x_cnt) == CMAX, "R13 unusable sat", x_cnt, CMAX);

        rst = 1; @(negedge clk); rst = 0; @(negedge clk);
        chk(u_cnt == 0 && x_cnt == 0, "R13 reset clears", {u_cnt, x_cnt}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule